// File: doc/BRIEF.md
# Strap-Configured Host Bus Slave Bridge

This block lets an 8-bit host processor read and write a 256-byte internal register space over an asynchronous parallel bus. Two strap pins are captured while reset is held, and they fix how the bus is interpreted until the next reset.

The strobe strap selects between two strobe styles. One style uses a direction line together with an active-low data strobe. The other uses separate active-low read and write strobes. The address strap selects how the address reaches the block. In one style, an address-latch pulse captures the address from the shared AD bus on its falling edge. In the other, a select line marks a write strobe as carrying an address byte rather than a data byte.

Host strobes are synchronized into the local clock domain before any edge is detected. A ready output tells the host when the block can accept the next access. An interrupt output has a polarity and a signalling style that software selects through a control register.

Top module: `hostbus_bridge`

## Requirements
- R1: `strap_strobe` and `strap_addr` are sampled on every clock edge while `rst_n` is low, and the value from the last such edge is kept. Changes on these pins while `rst_n` is high have no effect.
- R2: Strobe strap = 1 (separate strobes): `pin_a` is an active-low read strobe and `pin_b` is an active-low write strobe. A write commits on the rising edge of `pin_b`.
- R3: Strobe strap = 0 (direction plus strobe): `pin_a` is the direction line (1 = read, 0 = write) and `pin_b` is an active-low data strobe. A write commits on the rising edge of `pin_b` when `pin_a` is 0. A read is active while `pin_b` is low and `pin_a` is 1.
- R4: Address strap = 0: a falling edge of `ale_sel` while `cs_n` is low loads `ad_in` into the address register.
- R5: Address strap = 1: at a write commit, if `ale_sel` is 1 the byte is loaded into the address register; if `ale_sel` is 0 the byte is written to the current address. The address register does not change after a data write.
- R6: `ad_oe` is 1 only while a read is active with `cs_n` low, seen two clocks late through the synchronizers. While `ad_oe` is 1, `ad_out` shows the byte at the current address.
- R7: Strobes and latch edges seen while `cs_n` is high are ignored: no write, no address change, and `ready` stays high.
- R8: A write commits, and `ready` goes low, on the third clock edge after the strobe's trailing edge. `ready` then stays low for exactly BUSY_CYC clocks (default 3). The trailing edge of a read strobe also starts the same busy window.
- R9: The control register is at address 0xFF and resets to 0. Bit 0 sets the polarity (1 = `irq` active high, 0 = active low). Bit 1 sets the signalling style (1 = pulse, 0 = level).
- R10: A high `irq_req` sets a pending flag. In level style, `irq` stays asserted while the flag is set. A write to address 0xFE with bit 0 = 1 clears the flag, and that write does not store the byte. A read of 0xFE returns the flag in bit 0 and zeros in the other bits.
- R11: In pulse style, a high `irq_req` asserts `irq` for exactly PULSE_W clocks (default 4), starting at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are captured while it is low |
| strap_strobe | input | 1 | Strobe-style strap |
| strap_addr | input | 1 | Address-style strap |
| cs_n | input | 1 | Active-low chip select |
| pin_a | input | 1 | Read strobe, or direction line, depending on the strobe strap |
| pin_b | input | 1 | Write strobe, or data strobe, depending on the strobe strap |
| ale_sel | input | 1 | Address-latch enable, or address/data select, depending on the address strap |
| ad_in | input | 8 | Bus value driven by the host |
| ad_out | output | 8 | Read data for the host |
| ad_oe | output | 1 | Enables the bus driver during a read |
| ready | output | 1 | High when the next access may start |
| irq_req | input | 1 | Internal interrupt event, one clock wide |
| irq | output | 1 | Interrupt output |

## Verification
The same write, re-address and readback sequence is run under all four strap combinations. Because of this, a wrong decode of `pin_a`/`pin_b` or of `ale_sel` shows up as a wrong byte read back, or as a missing busy window, in only the affected style. Two addresses are written and then read back in alternation, which separates real address capture from a stuck address register. Writes made with chip select high, and strap pins changed after reset, show that ignored inputs leave the stored data and `ready` unchanged. The interrupt is exercised first in active-low level style, including a readback of the pending flag and its clear, and then in active-high pulse style, where the asserted cycles are counted.

// File: rtl/hostbus_bridge.sv
module hostbus_bridge #(
  parameter int W        = 8,
  parameter int BUSY_CYC = 3,
  parameter int PULSE_W  = 4,
  parameter int CTRL_REG = 255,
  parameter int STAT_REG = 254
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap_strobe,
  input  logic         strap_addr,
  input  logic         cs_n,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic         ale_sel,
  input  logic [W-1:0] ad_in,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic         ready,
  input  logic         irq_req,
  output logic         irq
);
  localparam int DEPTH = 1 << W;
  localparam int BW    = $clog2(BUSY_CYC + 1);
  localparam int PCW   = $clog2(PULSE_W + 1);

  logic mode_sep_q, addr_flag_q;
  logic [2:0] cs_s, a_s, b_s, l_s;
  logic [2:0][W-1:0] ad_s;
  logic [W-1:0] regs [DEPTH];
  logic [W-1:0] addr_q;
  logic [BW-1:0] busy;
  logic [PCW-1:0] pcnt;
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_sep_q  <= strap_strobe;
      addr_flag_q <= strap_addr;
      cs_s <= '1;
      a_s  <= '1;
      b_s  <= '1;
      l_s  <= '0;
      ad_s <= '0;
    end else begin
      cs_s <= {cs_s[1:0], cs_n};
      a_s  <= {a_s[1:0], pin_a};
      b_s  <= {b_s[1:0], pin_b};
      l_s  <= {l_s[1:0], ale_sel};
      ad_s <= {ad_s[1:0], ad_in};
    end
  end

  wire          cs_ok    = ~cs_s[2];
  wire          b_rise   = ~b_s[2] & b_s[1] & cs_ok;
  wire          a_rise   = ~a_s[2] & a_s[1] & cs_ok;
  wire          wr_end   = mode_sep_q ? b_rise : (b_rise & ~a_s[2]);
  wire          rd_end   = mode_sep_q ? a_rise : (b_rise & a_s[2]);
  wire          ale_fall = ~addr_flag_q & l_s[2] & ~l_s[1] & cs_ok;
  wire          addr_wr  = wr_end & addr_flag_q & l_s[2];
  wire          data_wr  = wr_end & ~(addr_flag_q & l_s[2]);
  wire [W-1:0]  wdat     = ad_s[2];
  wire          at_stat  = (addr_q == W'(STAT_REG));
  wire          stat_clr = data_wr & at_stat & wdat[0];
  wire [W-1:0]  ctrl     = regs[W'(CTRL_REG)];
  wire          pol      = ctrl[0];
  wire          pulse    = ctrl[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      addr_q <= '0;
    end else begin
      if (data_wr && !at_stat) regs[addr_q] <= wdat;
      if (addr_wr || ale_fall) addr_q <= wdat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= '0;
      pcnt    <= '0;
      pending <= 1'b0;
    end else begin
      if (wr_end || rd_end) busy <= BW'(BUSY_CYC);
      else if (busy != '0)  busy <= busy - 1'b1;
      if (irq_req && pulse) pcnt <= PCW'(PULSE_W);
      else if (pcnt != '0)  pcnt <= pcnt - 1'b1;
      if (irq_req)          pending <= 1'b1;
      else if (stat_clr)    pending <= 1'b0;
    end
  end

  wire active = pulse ? (pcnt != '0) : pending;
  assign irq    = pol ? active : ~active;
  assign ready  = (busy == '0);
  assign ad_oe  = ~cs_s[1] & (mode_sep_q ? ~a_s[1] : (~b_s[1] & a_s[1]));
  assign ad_out = at_stat ? {{(W-1){1'b0}}, pending} : regs[addr_q];
endmodule

// File: rtl/hostbus_bridge_chk.sv
module hostbus_bridge_chk #(
  parameter int BUSY_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic ad_oe,
  input logic ready,
  input logic irq_req,
  input logic irq,
  input logic pol,
  input logic pulse,
  input logic pending,
  input logic stat_clr,
  input logic mode_sep,
  input logic addr_flag
);
  int low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      low_cnt <= 0;
    else if (!ready) low_cnt <= low_cnt + 1;
    else             low_cnt <= 0;
  end

  a_r1_straps_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mode_sep) && $stable(addr_flag)));

  a_r6_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> ($past(cs_n, 2) == 1'b0));

  a_r8_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (low_cnt >= BUSY_CYC));

  a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && pending && !stat_clr) |=> pending);

  a_r11_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && pulse) |=> (irq == pol));
endmodule

bind hostbus_bridge hostbus_bridge_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ad_oe(ad_oe), .ready(ready),
  .irq_req(irq_req), .irq(irq), .pol(pol), .pulse(pulse),
  .pending(pending), .stat_clr(stat_clr),
  .mode_sep(mode_sep_q), .addr_flag(addr_flag_q)
);

// File: tb/hostbus_bridge_tb.sv
module hostbus_bridge_tb;
  localparam int BUSY = 3;
  localparam int PW   = 4;
  localparam logic [11:0] IDLE = 12'hE00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_strobe = 1'b0, strap_addr = 1'b0;
  logic cs_n = 1'b1, pin_a = 1'b1, pin_b = 1'b1, ale_sel = 1'b0, irq_req = 1'b0;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic ad_oe, ready, irq;

  int checks = 0, fails = 0;
  bit cur_sep, cur_af;

  always #4 clk = ~clk;

  hostbus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .strap_strobe(strap_strobe), .strap_addr(strap_addr),
    .cs_n(cs_n), .pin_a(pin_a), .pin_b(pin_b), .ale_sel(ale_sel), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ready(ready), .irq_req(irq_req), .irq(irq)
  );

  // behavioural reference
  logic m_sep, m_af, m_pend;
  logic [7:0] m_mem [256];
  logic [7:0] m_addr;
  int m_busy, m_pcnt;
  logic [11:0] h0, h1, h2, cur, prv;
  logic csok, brise, arise, wr, rd, clr;
  logic [7:0] ctl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sep = strap_strobe; m_af = strap_addr;
      for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
      m_addr = 8'h00; m_busy = 0; m_pcnt = 0; m_pend = 1'b0;
      h0 = IDLE; h1 = IDLE; h2 = IDLE;
    end else begin
      cur = h1; prv = h2;
      csok  = !prv[11];
      brise = !prv[9] && cur[9] && csok;
      arise = !prv[10] && cur[10] && csok;
      wr = m_sep ? brise : (brise && !prv[10]);
      rd = m_sep ? arise : (brise && prv[10]);
      ctl = m_mem[255];
      clr = 1'b0;
      if (wr) begin
        if (m_af && prv[8]) m_addr = prv[7:0];
        else if (m_addr == 8'hFE) clr = prv[0];
        else m_mem[m_addr] = prv[7:0];
      end
      if (!m_af && prv[8] && !cur[8] && csok) m_addr = prv[7:0];
      if (irq_req) m_pend = 1'b1; else if (clr) m_pend = 1'b0;
      if (irq_req && ctl[1]) m_pcnt = PW; else if (m_pcnt > 0) m_pcnt--;
      if (wr || rd) m_busy = BUSY; else if (m_busy > 0) m_busy--;
      h2 = h1; h1 = h0; h0 = {cs_n, pin_a, pin_b, ale_sel, ad_in};
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_oe, act;
      logic [7:0] c;
      e_oe = !h1[11] && (m_sep ? !h1[10] : (!h1[9] && h1[10]));
      c = m_mem[255];
      act = c[1] ? (m_pcnt > 0) : m_pend;
      chk("R8 ready", int'(ready), int'(m_busy == 0));
      chk("R6 ad_oe", int'(ad_oe), int'(e_oe));
      if (e_oe) chk("R6 ad_out", int'(ad_out),
                    (m_addr == 8'hFE) ? int'(m_pend) : int'(m_mem[m_addr]));
      chk("R10/R11 irq", int'(irq), int'(c[0] ? act : !act));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit s, bit a);
    rst_n = 1'b0; strap_strobe = s; strap_addr = a;
    cur_sep = s; cur_af = a;
    cs_n = 1'b1; pin_a = 1'b1; pin_b = 1'b1; ale_sel = 1'b0; ad_in = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic host_addr(logic [7:0] a);
    cs_n = 1'b0; ale_sel = 1'b1; ad_in = a;
    if (!cur_af) begin
      tick(4); ale_sel = 1'b0; tick(4); cs_n = 1'b1; tick(2);
    end else begin
      if (!cur_sep) pin_a = 1'b0;
      pin_b = 1'b0; tick(4); pin_b = 1'b1; tick(8);
      pin_a = 1'b1; ale_sel = 1'b0; cs_n = 1'b1; tick(2);
    end
  endtask

  task automatic host_wr(logic [7:0] d, logic cs, int exp_low, string tag);
    int lows = 0;
    cs_n = cs; ale_sel = 1'b0; ad_in = d;
    if (!cur_sep) pin_a = 1'b0;
    pin_b = 1'b0; tick(4); pin_b = 1'b1;
    repeat (8) begin @(negedge clk); if (!ready) lows++; end
    chk(tag, lows, exp_low);
    @(posedge clk); #1;
    pin_a = 1'b1; cs_n = 1'b1; tick(2);
  endtask

  task automatic host_rd(output logic [7:0] v, output logic oe);
    cs_n = 1'b0;
    if (cur_sep) pin_a = 1'b0; else begin pin_a = 1'b1; pin_b = 1'b0; end
    tick(4);
    @(negedge clk); v = ad_out; oe = ad_oe;
    @(posedge clk); #1;
    pin_a = 1'b1; pin_b = 1'b1; cs_n = 1'b1; tick(8);
  endtask

  initial begin : main
    logic [7:0] v;
    logic oe;
    bit sv [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
    bit av [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
    for (int k = 0; k < 4; k++) begin
      string ts, ta;
      do_reset(sv[k], av[k]);
      ts = sv[k] ? "R2" : "R3";
      ta = av[k] ? "R5" : "R4";
      @(negedge clk);
      chk("R8 reset ready", int'(ready), 1);
      chk("R9 reset irq idle low-active", int'(irq), 1);
      @(posedge clk); #1;
      if (k == 0) begin strap_strobe = 1'b0; strap_addr = 1'b0; end
      host_addr(8'h12 + 8'(k));
      host_wr(8'hA5 ^ 8'(k), 1'b0, BUSY, "R8 write busy");
      host_addr(8'h40);
      host_wr(8'h3C, 1'b0, BUSY, "R8 write busy");
      host_addr(8'h12 + 8'(k));
      host_rd(v, oe);
      chk(ts, int'(v), int'(8'hA5 ^ 8'(k)));
      chk("R6 oe during read", int'(oe), 1);
      if (k == 0) chk("R1 straps ignored after reset", int'(v), int'(8'hA5));
      host_addr(8'h40);
      host_rd(v, oe);
      chk(ta, int'(v), 8'h3C);
      host_wr(8'hFF, 1'b1, 0, "R7 no busy with cs high");
      host_rd(v, oe);
      chk("R7 cs-high write ignored", int'(v), 8'h3C);
      if (av[k]) begin
        host_addr(8'h50);
        host_wr(8'h11, 1'b0, BUSY, "R5 first data");
        host_wr(8'h22, 1'b0, BUSY, "R5 second data");
        host_rd(v, oe);
        chk("R5 address kept after data write", int'(v), 8'h22);
      end
    end
    @(posedge clk); #1;
    irq_req = 1'b1; tick(1); irq_req = 1'b0;
    @(negedge clk);
    chk("R10 level irq asserted low", int'(irq), 0);
    @(posedge clk); #1;
    host_addr(8'hFE);
    host_rd(v, oe);
    chk("R10 pending readback", int'(v), 1);
    host_wr(8'h01, 1'b0, BUSY, "R8 write busy");
    @(negedge clk);
    chk("R10 cleared", int'(irq), 1);
    @(posedge clk); #1;
    host_addr(8'hFF);
    host_wr(8'h03, 1'b0, BUSY, "R8 write busy");
    @(negedge clk);
    chk("R9 active-high idle", int'(irq), 0);
    @(posedge clk); #1;
    irq_req = 1'b1; tick(1); irq_req = 1'b0;
    begin
      int highs = 0;
      repeat (10) begin @(negedge clk); if (irq) highs++; end
      chk("R11 pulse width", highs, PW);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule